// File: doc/BRIEF.md
# Boot Image Checksum Verifier

This reset-time sequencer sits between the built-in logic self-test and the core's first instruction fetch. It waits for the self-test to report completion. If the self-test reports a failure, the sequencer moves straight to a failed verdict. Otherwise it reads a fixed number of 32-bit words from the start of memory, one at a time, over a request/ready read port, and adds them up modulo 2^32.

When the eighth word has been added, the block judges the image. A sum whose 32 bits are all zero marks the boot image as valid. In that case the failure output drops and the core receives a single-cycle start pulse. Any other sum keeps the failure output high and the core is never started. Either verdict holds until the next reset.

The failure output is high from reset onward and falls only on a confirmed pass. A system can therefore treat it as a plain "not ready / broken" indicator.

Top module: `boot_image_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fail_o` is 1, `mem_req` is 0 and `core_start` is 0.
- R2: Before `bist_done` is seen high, no memory read is requested and `fail_o` stays 1.
- R3: If `bist_done` is seen with `bist_pass` = 0, the block never raises `mem_req` or `core_start`, and `fail_o` stays 1 until reset.
- R4: After a passing self-test, reads are issued at byte addresses 0x00, 0x04, ... 0x1C in ascending order, one word per accepted handshake. A handshake is a cycle with both `mem_req` and `mem_ready` high. `mem_addr` holds steady while a request waits for `mem_ready`.
- R5: `mem_req` stays high from the cycle after `bist_done` is accepted until exactly eight handshakes have completed, and is low afterwards.
- R6: If the eight words sum to zero modulo 2^32, `fail_o` falls to 0 and `core_start` is 1 for exactly one cycle.
- R7: If any bit of the 32-bit sum is nonzero, including sums that need no wrap, `fail_o` stays 1 and `core_start` never rises.
- R8: Once a verdict is reached it is sticky. Further `bist_done` pulses cause no reads, no start pulse and no change of `fail_o` until reset.
- R9: The verdict (`fail_o` value and `core_start` pulse) appears on the second rising edge after the edge that accepts the eighth word.
- R10: `mem_rdata` is ignored in cycles without a handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_done | input | 1 | Self-test has finished (sampled while waiting) |
| bist_pass | input | 1 | Self-test outcome, 1 = passed, valid with `bist_done` |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ready | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 32 | Read data |
| fail_o | output | 1 | Failure indicator, high until a pass is confirmed |
| core_start | output | 1 | One-cycle pulse releasing the core |

## Verification
Every result of this block has a fixed distance from the stimulus that causes it. The first request is visible one edge after `bist_done` is accepted, and each new address is visible one edge after the previous handshake. The verdict appears two edges after the eighth handshake, and the start pulse is gone one edge later. The bench drives inputs and samples outputs on falling edges and counts edges from each stimulus, so every check samples exactly in the cycle the requirement names. The memory model uses several fixed ready latencies and puts junk on the data bus while it is not ready. This makes address holding and data ignoring observable in the same runs.

// File: rtl/boot_chk_pkg.sv
package boot_chk_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_BIST,
    ST_READ,
    ST_JUDGE,
    ST_PASS,
    ST_FAIL
  } bc_state_e;
endpackage

// File: rtl/bc_addr_seq.sv
module bc_addr_seq #(
  parameter int NUM_WORDS  = 8,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic              last_word,
  output logic [ADDR_W-1:0] addr
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0] idx_q;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [IDX_W-1:0] i);
    return BASE_ADDR + ADDR_W'(i) * ADDR_W'(WORD_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_q <= '0;
    else if (step && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
  end

  assign last_word = (idx_q == LAST_IDX);
  assign addr      = word_addr(idx_q);

  // R4: index never passes the last word
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R4: a step moves the address on by exactly one word
  a_r4_step_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !last_word) |=> (addr == $past(addr) + ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/bc_accum.sv
module bc_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [DATA_W-1:0] din,
  output logic              sum_zero
);
  logic [DATA_W-1:0] sum_q;

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum_q <= '0;
    else if (add_en)   sum_q <= wrap_add(sum_q, din);
  end

  assign sum_zero = (sum_q == '0);

  // R10: without an accepted word the sum does not move
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !clr) |=> $stable(sum_q));
endmodule

// File: rtl/boot_image_checker.sv
module boot_image_checker #(
  parameter int NUM_WORDS  = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = DATA_W / 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_done,
  input  logic              bist_pass,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fail_o,
  output logic              core_start
);
  import boot_chk_pkg::*;

  bc_state_e st_q, st_d;
  logic      start_q;

  // named internal events
  logic rd_accept;
  logic last_word;
  logic enter_read;
  logic sum_zero;
  logic judge_pass;

  assign rd_accept  = mem_req && mem_ready;
  assign enter_read = (st_q == ST_WAIT_BIST) && bist_done && bist_pass;
  assign judge_pass = (st_q == ST_JUDGE) && sum_zero;

  bc_addr_seq #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .BASE_ADDR (BASE_ADDR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (enter_read),
    .step     (rd_accept),
    .last_word(last_word),
    .addr     (mem_addr)
  );

  bc_accum #(
    .DATA_W(DATA_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (enter_read),
    .add_en  (rd_accept),
    .din     (mem_rdata),
    .sum_zero(sum_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT_BIST: if (bist_done) st_d = bist_pass ? ST_READ : ST_FAIL;
      ST_READ:      if (rd_accept && last_word) st_d = ST_JUDGE;
      ST_JUDGE:     st_d = sum_zero ? ST_PASS : ST_FAIL;
      ST_PASS:      st_d = ST_PASS;
      ST_FAIL:      st_d = ST_FAIL;
      default:      st_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT_BIST;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= judge_pass;
    end
  end

  assign mem_req    = (st_q == ST_READ);
  assign fail_o     = (st_q != ST_PASS);
  assign core_start = start_q;

  // R6: start is a single-cycle pulse
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R6: start only accompanies a cleared failure flag
  a_r6_start_with_pass: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !fail_o);
  // R3: a failed verdict never requests memory or starts the core
  a_r3_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL) |-> (!mem_req && !core_start));
  // R8: verdicts are sticky
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL) |=> (st_q == ST_FAIL));
  a_r8_pass_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_o |=> !fail_o);
  // R4: address holds while waiting for ready
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R9: accepting the last word leads to the judging cycle
  a_r9_judge_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && last_word) |=> (!mem_req && fail_o && !core_start));
  // R2: no request before the self-test is done
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_BIST) |-> (!mem_req && fail_o));
endmodule

// File: tb/test_boot_image_checker.sv
module test_boot_image_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bist_done, bist_pass;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        fail_o, core_start;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  logic [31:0] img [8];

  always #4 clk = ~clk;

  boot_image_checker i_boot_image_checker (
    .clk(clk), .rst_n(rst_n), .bist_done(bist_done), .bist_pass(bist_pass),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .fail_o(fail_o), .core_start(core_start)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bist_done = 1'b0; bist_pass = 1'b0;
    mem_ready = 1'b0; mem_rdata = 32'hA5A5_5A5A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(fail_o === 1'b1, "R1 fail_o in reset", {31'd0, fail_o}, 32'd1);
      check(mem_req === 1'b0, "R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
      check(core_start === 1'b0, "R1 core_start in reset", {31'd0, core_start}, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(fail_o === 1'b1 && mem_req === 1'b0 && core_start === 1'b0,
          "R1 after release", {29'd0, fail_o, mem_req, core_start}, 32'd4);
  endtask

  task automatic idle_then_bist(input bit pass, input int idle);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check(mem_req === 1'b0 && fail_o === 1'b1, "R2 idle before bist_done",
            {30'd0, mem_req, fail_o}, 32'd1);
    end
    bist_done = 1'b1; bist_pass = pass;
    @(negedge clk);
    bist_done = 1'b0; bist_pass = 1'b0;
  endtask

  // R8: a verdict does not move on another bist_done
  task automatic poke_after_verdict(input logic exp_fail);
    bist_done = 1'b1; bist_pass = 1'b1; mem_ready = 1'b1;
    @(negedge clk);
    bist_done = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(mem_req === 1'b0 && core_start === 1'b0 && fail_o === exp_fail,
            "R8 sticky verdict", {29'd0, mem_req, core_start, fail_o},
            {31'd0, exp_fail});
    end
    mem_ready = 1'b0;
  endtask

  task automatic run_image(input int lat);
    logic [63:0] total;
    logic exp_pass;
    int got, waitc, cyc;
    total = 64'd0;
    for (int i = 0; i < 8; i++) total = total + {32'd0, img[i]};
    exp_pass = (total[31:0] == 32'd0);
    do_reset();
    idle_then_bist(1'b1, 2 + lat);
    got = 0; waitc = 0; cyc = 0;
    while (got < 8 && cyc < 400) begin
      check(mem_req === 1'b1, "R5 request held while reading", {31'd0, mem_req}, 32'd1);
      check(mem_addr === 32'(got * 4), "R4 address order", mem_addr, 32'(got * 4));
      check(fail_o === 1'b1 && core_start === 1'b0, "R9 no early verdict",
            {30'd0, fail_o, core_start}, 32'd2);
      if (waitc >= lat) begin
        mem_ready = 1'b1; mem_rdata = img[got]; got++; waitc = 0;
      end else begin
        mem_ready = 1'b0; mem_rdata = 32'hDEAD_0000 | 32'(cyc); waitc++;
      end
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = 32'h1234_5678;
      cyc++;
    end
    // judging cycle
    check(mem_req === 1'b0, "R5 request ends after eight words", {31'd0, mem_req}, 32'd0);
    check(fail_o === 1'b1 && core_start === 1'b0, "R9 judge cycle holds",
          {30'd0, fail_o, core_start}, 32'd2);
    @(negedge clk);
    if (exp_pass)
      check(fail_o === 1'b0 && core_start === 1'b1, "R6 pass verdict",
            {30'd0, fail_o, core_start}, 32'd1);
    else
      check(fail_o === 1'b1 && core_start === 1'b0, "R7 nonzero sum verdict",
            {30'd0, fail_o, core_start}, 32'd2);
    @(negedge clk);
    check(core_start === 1'b0 && fail_o === !exp_pass, "R6 pulse one cycle",
          {30'd0, fail_o, core_start}, {30'd0, !exp_pass, 1'b0});
    poke_after_verdict(!exp_pass);
  endtask

  function automatic logic [31:0] mix(input int seed, input int i);
    return 32'h9E37_79B9 * 32'(seed * 8 + i + 1) ^ 32'(seed << (i + 3));
  endfunction

  task automatic make_zero_image(input int seed);
    logic [31:0] s;
    s = 32'd0;
    for (int i = 0; i < 7; i++) begin
      img[i] = mix(seed, i);
      s = s + img[i];
    end
    img[7] = 32'd0 - s;
  endtask

  initial begin
    // zero-sum images with several ready latencies
    for (int seed = 1; seed <= 8; seed++) begin
      make_zero_image(seed);
      run_image(seed % 4);
    end
    // all zeros
    for (int i = 0; i < 8; i++) img[i] = 32'd0;
    run_image(0);
    // wrap exactly to zero
    for (int i = 0; i < 8; i++) img[i] = 32'h2000_0000;
    run_image(1);
    // top bit only
    for (int i = 0; i < 8; i++) img[i] = 32'h1000_0000;
    run_image(2);
    // single-bit error sweep over every sum bit
    for (int b = 0; b < 32; b++) begin
      make_zero_image(b + 20);
      img[b % 8] = img[b % 8] + (32'd1 << b);
      run_image(b % 3);
    end
    // R3: self-test failure skips the read phase
    do_reset();
    idle_then_bist(1'b0, 3);
    mem_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      check(mem_req === 1'b0 && core_start === 1'b0 && fail_o === 1'b1,
            "R3 self-test failure", {29'd0, mem_req, core_start, fail_o}, 32'd1);
      @(negedge clk);
    end
    mem_ready = 1'b0;
    poke_after_verdict(1'b1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule